// File: doc/BRIEF.md
# Packet-Walking OTP Read Controller

This block is the read side of a one-time-programmable word array whose contents are laid out as a chain of variable-length packets. Each packet begins with one 32-bit header word. An 8-bit size field in that header, at bits 15:8, gives a value N. The packet then carries N+1 payload words, so the next header sits N+2 words further on. Software writes a target word address into the mode register and then sets the go bit in the control register. The controller walks the header chain from word 0 until it reaches the packet whose span covers the target. It then copies that packet's header and payload into a local buffer, and status bit 6 reads as busy while this happens.

When the copy is done, the header can be read at offset 0x20. The payload is read one word at a time through the data register at 0x24, under a read pointer that is loaded through the index register at 0x08. Any target inside a packet's span loads the whole packet, so the data that is returned does not depend on where in the packet the target falls. If the walk meets a header with size 0, or runs past the end of the array, before it covers the target, the controller stops and raises an error flag instead. A plain write port fills the array model before any reads are made.

Top module: `otp_pkt_reader`

## Requirements
- R1: Register offsets on the 8-bit bus address are control 0x00, mode 0x04, index 0x08, status 0x0C, header 0x20 and data 0x24. The mode register reads back the last value written to it. Reads of the control register return 0.
- R2: A write to 0x00 with bit 6 set, made while the block is idle, sets status bit 6 (busy) from the next cycle on. It also latches mode bits 31:16 as the target word address.
- R3: Busy clears by itself once the transfer ends. Status bit 0 (error) is cleared when a transfer starts, and is never set while busy is set.
- R4: A packet starting at word S with size field N covers the words S to S+N+1. A target inside that span loads that packet, and its header word then reads at 0x20 with status 0.
- R5: A write to 0x08 loads the payload read pointer, and a start sets it to 0. Each read of 0x24 returns the payload word at the pointer (index 0 is the word right after the header) and advances the pointer by one. A packet has N+1 payload words. Payload words beyond the array end read as 0.
- R6: A read of 0x24 with the pointer at or past the last payload word returns 0 and leaves the pointer where it is.
- R7: If the walk meets a header with size 0, or reaches a position at or beyond the array size, before it covers the target, status reads 0x01 (error set, busy clear) and the header reads 0.
- R8: Writes to the control register while busy have no effect. A later write to the mode register does not change the target of the transfer already running.
- R9: A fill write stores fill_data at array word fill_addr, and later transfers read that value.
- R10: After reset the mode, index, status and header registers and the data register all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances the data pointer) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| fill_we | input | 1 | Array fill write enable |
| fill_addr | input | $clog2(WORDS) | Array fill word address |
| fill_data | input | 32 | Array fill word |

## Verification
The bench builds the block with WORDS set to 96 instead of 2816. With that size, a randomly generated packet chain can run off the end of the array within a few dozen words. This brings the array-end error and truncated last packets within reach, and also makes room for a chain that ends on a zero-size header followed by random words. The size field keeps its full 8-bit width, so the payload buffer has its default 256 entries, but the random packets stay short so that many of them fit into the array. Walks over ten or more packets are long enough that control writes land while the block is still busy.

// File: rtl/otp_rd_pkg.sv
package otp_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_HDR_ADDR = 3'd1,
        ST_HDR_CHK  = 3'd2,
        ST_COPY     = 3'd3,
        ST_DRAIN    = 3'd4
    } walk_st_e;

    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_MODE = 8'h04;
    localparam logic [7:0] OFS_IDX  = 8'h08;
    localparam logic [7:0] OFS_STAT = 8'h0C;
    localparam logic [7:0] OFS_HDR  = 8'h20;
    localparam logic [7:0] OFS_DATA = 8'h24;

    localparam int CTRL_GO_BIT   = 6;
    localparam int STAT_BUSY_BIT = 6;
    localparam int STAT_ERR_BIT  = 0;

endpackage

// File: rtl/otp_array.sv
module otp_array #(
    parameter int WORDS = 2816,
    parameter int AW    = 12,
    parameter int PW    = 13
) (
    input  logic          clk,
    input  logic          fill_we,
    input  logic [AW-1:0] fill_addr,
    input  logic [31:0]   fill_data,
    input  logic          rd_en,
    input  logic [PW-1:0] rd_addr,
    output logic [31:0]   rd_data
);

    logic [31:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (fill_we) begin
            cells[fill_addr] <= fill_data;
        end
        if (rd_en) begin
            // positions beyond the array read as zero
            rd_data <= (rd_addr < PW'(WORDS)) ? cells[rd_addr[AW-1:0]] : 32'h0;
        end
    end

endmodule

// File: rtl/otp_payload_buf.sv
module otp_payload_buf #(
    parameter int DEPTH = 256,
    parameter int IW    = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [31:0]   wr_word,
    input  logic [IW-1:0] rd_idx,
    output logic [31:0]   rd_word
);

    logic [31:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slots[wr_idx] <= wr_word;
        end
    end

    assign rd_word = slots[rd_idx];

endmodule

// File: rtl/otp_pkt_reader.sv
module otp_pkt_reader
    import otp_rd_pkg::*;
#(
    parameter int WORDS    = 2816,
    parameter int SIZE_LSB = 8,
    parameter int SIZE_W   = 8,
    parameter int TGT_LSB  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic                     reg_rd,
    input  logic [7:0]               reg_addr,
    input  logic [31:0]              reg_wdata,
    output logic [31:0]              reg_rdata,
    input  logic                     fill_we,
    input  logic [$clog2(WORDS)-1:0] fill_addr,
    input  logic [31:0]              fill_data
);

    localparam int AW    = $clog2(WORDS);
    localparam int PW    = $clog2(WORDS + (1 << SIZE_W) + 2) + 1;
    localparam int IW    = SIZE_W;
    localparam int DEPTH = 1 << SIZE_W;
    localparam int CW    = (PW > 16) ? PW : 16;

    typedef struct packed {
        walk_st_e        st;
        logic [PW-1:0]   pos;
        logic [15:0]     tgt;
        logic [31:0]     hdr;
        logic [IW:0]     nwords;
        logic [IW:0]     iss;
        logic            cap_v;
        logic [IW-1:0]   cap_idx;
        logic            err;
        logic [31:0]     mode;
        logic [IW:0]     idx;
    } state_t;

    state_t q, d;

    logic          arr_en;
    logic [PW-1:0] arr_addr;
    logic [31:0]   arr_rdata;
    logic [31:0]   buf_word;
    logic [IW-1:0] size_f;
    logic [PW-1:0] pkt_end;
    logic          ctrl_go;
    logic          data_pop;

    // signals also observed by the checker
    logic          stat_busy;
    logic          stat_err;
    logic [31:0]   hdr_word;
    logic [IW:0]   rd_ptr;
    logic [IW:0]   ptr_lim;

    otp_array #(.WORDS(WORDS), .AW(AW), .PW(PW)) u_array (
        .clk       (clk),
        .fill_we   (fill_we),
        .fill_addr (fill_addr),
        .fill_data (fill_data),
        .rd_en     (arr_en),
        .rd_addr   (arr_addr),
        .rd_data   (arr_rdata)
    );

    otp_payload_buf #(.DEPTH(DEPTH), .IW(IW)) u_buf (
        .clk     (clk),
        .wr_en   (q.cap_v),
        .wr_idx  (q.cap_idx),
        .wr_word (arr_rdata),
        .rd_idx  (q.idx[IW-1:0]),
        .rd_word (buf_word)
    );

    assign size_f   = arr_rdata[SIZE_LSB +: SIZE_W];
    assign pkt_end  = q.pos + PW'(size_f) + PW'(2);
    assign ctrl_go  = reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[CTRL_GO_BIT];
    assign data_pop = reg_rd && (reg_addr == OFS_DATA) && (q.idx < q.nwords);

    always_comb begin
        d        = q;
        d.cap_v  = 1'b0;
        arr_en   = 1'b0;
        arr_addr = q.pos;

        // register side
        if (data_pop) begin
            d.idx = q.idx + (IW+1)'(1);
        end
        if (reg_wr && reg_addr == OFS_MODE) begin
            d.mode = reg_wdata;
        end
        if (reg_wr && reg_addr == OFS_IDX) begin
            d.idx = reg_wdata[IW:0];
        end

        // header walk and packet copy
        case (q.st)
            ST_IDLE: begin
                if (ctrl_go) begin
                    d.st     = ST_HDR_ADDR;
                    d.pos    = '0;
                    d.tgt    = q.mode[TGT_LSB +: 16];
                    d.err    = 1'b0;
                    d.hdr    = '0;
                    d.nwords = '0;
                    d.idx    = '0;
                end
            end
            ST_HDR_ADDR: begin
                if (q.pos >= PW'(WORDS)) begin
                    d.err = 1'b1;
                    d.st  = ST_IDLE;
                end else begin
                    arr_en = 1'b1;
                    d.st   = ST_HDR_CHK;
                end
            end
            ST_HDR_CHK: begin
                if (size_f == '0) begin
                    d.err = 1'b1;
                    d.st  = ST_IDLE;
                end else if (CW'(q.tgt) < CW'(pkt_end)) begin
                    d.hdr    = arr_rdata;
                    d.nwords = (IW+1)'(size_f) + (IW+1)'(1);
                    d.iss    = '0;
                    d.st     = ST_COPY;
                end else begin
                    d.pos = pkt_end;
                    d.st  = ST_HDR_ADDR;
                end
            end
            ST_COPY: begin
                arr_en    = 1'b1;
                arr_addr  = q.pos + PW'(1) + PW'(q.iss);
                d.cap_v   = 1'b1;
                d.cap_idx = q.iss[IW-1:0];
                d.iss     = q.iss + (IW+1)'(1);
                if (q.iss == q.nwords - (IW+1)'(1)) begin
                    d.st = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                d.st = ST_IDLE;
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign stat_busy = (q.st != ST_IDLE);
    assign stat_err  = q.err;
    assign hdr_word  = q.hdr;
    assign rd_ptr    = q.idx;
    assign ptr_lim   = q.nwords;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_MODE: reg_rdata = q.mode;
            OFS_IDX:  reg_rdata = 32'(q.idx);
            OFS_STAT: begin
                reg_rdata[STAT_BUSY_BIT] = stat_busy;
                reg_rdata[STAT_ERR_BIT]  = q.err;
            end
            OFS_HDR:  reg_rdata = q.hdr;
            OFS_DATA: reg_rdata = (q.idx < q.nwords) ? buf_word : 32'h0;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/otp_pkt_reader_chk.sv
module otp_pkt_reader_chk #(
    parameter int IW = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic [7:0]  reg_addr,
    input logic        go_bit,
    input logic [31:0] reg_rdata,
    input logic        busy,
    input logic        err,
    input logic [31:0] hdr,
    input logic [IW:0] ptr,
    input logic [IW:0] lim
);

    // R2: a go write while idle makes the block busy on the next cycle
    a_r2_go_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 8'h00 && go_bit && !busy) |=> busy);

    // R3: the error flag and busy are never set together
    a_r3_no_err_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !err);

    // R7: an error leaves the header register at zero
    a_r7_err_hdr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (hdr == 32'h0));

    // R5: a data read inside the payload advances the pointer by one
    a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 8'h24 && ptr < lim && !reg_wr && !busy)
        |=> (ptr == $past(ptr) + 1'b1));

    // R6: a data read past the payload holds the pointer
    a_r6_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 8'h24 && ptr >= lim && !reg_wr && !busy)
        |=> $stable(ptr));

    // R6: a data read past the payload returns zero
    a_r6_zero_past_end: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 8'h24 && ptr >= lim) |-> (reg_rdata == 32'h0));

endmodule

bind otp_pkt_reader otp_pkt_reader_chk #(.IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .go_bit    (reg_wdata[6]),
    .reg_rdata (reg_rdata),
    .busy      (stat_busy),
    .err       (stat_err),
    .hdr       (hdr_word),
    .ptr       (rd_ptr),
    .lim       (ptr_lim)
);

// File: tb/otp_pkt_reader_tb.sv
module otp_pkt_reader_tb;

    localparam int WORDS = 96;
    localparam int AW    = $clog2(WORDS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          fill_we = 1'b0;
    logic [AW-1:0] fill_addr = '0;
    logic [31:0]   fill_data = '0;

    int total = 0;
    int bad = 0;
    logic [31:0] img [WORDS];
    int term_pos;

    always #10 clk = ~clk;

    otp_pkt_reader #(.WORDS(WORDS)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fill_we(fill_we), .fill_addr(fill_addr), .fill_data(fill_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic fill(input int a, input logic [31:0] v);
        @(negedge clk);
        fill_we = 1'b1; fill_addr = AW'(a); fill_data = v;
        img[a] = v;
        @(posedge clk); #1;
        fill_we = 1'b0;
    endtask

    function automatic logic [31:0] pkt_hdr(input int sz);
        logic [31:0] r;
        r = $urandom;
        r[15:8] = 8'(sz);
        return r;
    endfunction

    // chain ending on a zero-size header (stop=1) or running off the end
    task automatic build(input bit stop);
        int pos;
        pos = 0;
        for (int i = 0; i < WORDS; i++) fill(i, $urandom);
        while (stop ? (pos + 7 < 80) : (pos < WORDS)) begin
            int sz;
            sz = 1 + int'($urandom % 5);
            fill(pos, pkt_hdr(sz));
            pos = pos + sz + 2;
        end
        if (stop) begin
            logic [31:0] z;
            z = $urandom;
            z[15:8] = 8'h00;
            fill(pos, z);
        end
        term_pos = pos;
    endtask

    // expected packet start for a target, -1 for an error
    function automatic int find_pkt(input int t);
        int pos;
        pos = 0;
        forever begin
            int sz;
            if (pos >= WORDS) return -1;
            sz = int'(img[pos][15:8]);
            if (sz == 0) return -1;
            if (t < pos + sz + 2) return pos;
            pos = pos + sz + 2;
        end
    endfunction

    function automatic logic [31:0] img_at(input int a);
        return (a < WORDS) ? img[a] : 32'h0;
    endfunction

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            bus_rd(8'h0C, s);
            if (!s[6]) break;
        end
    endtask

    task automatic run_target(input int t);
        logic [31:0] v;
        int s;
        bus_wr(8'h04, 32'(t) << 16);
        bus_wr(8'h00, 32'h40);
        wait_idle();
        s = find_pkt(t);
        bus_rd(8'h0C, v);
        if (s < 0) begin
            chk(v == 32'h1, "R7 status on error", v, 32'h1);
            bus_rd(8'h20, v);
            chk(v == 32'h0, "R7 header on error", v, 32'h0);
        end else begin
            int n;
            chk(v == 32'h0, "R3 status after load", v, 32'h0);
            bus_rd(8'h20, v);
            chk(v == img[s], "R4 header of covering packet", v, img[s]);
            n = int'(img[s][15:8]) + 1;
            for (int k = 0; k < n; k++) begin
                bus_rd(8'h24, v);
                chk(v == img_at(s + 1 + k), "R5 R9 payload word", v, img_at(s + 1 + k));
            end
            bus_rd(8'h24, v);
            chk(v == 32'h0, "R6 read past payload", v, 32'h0);
            bus_rd(8'h08, v);
            chk(v == 32'(n), "R6 pointer held", v, 32'(n));
            bus_wr(8'h08, 32'h0);
            bus_rd(8'h24, v);
            chk(v == img_at(s + 1), "R5 index rewind", v, img_at(s + 1));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(1234));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10 reset state
        bus_rd(8'h04, v); chk(v == 0, "R10 mode after reset", v, 0);
        bus_rd(8'h08, v); chk(v == 0, "R10 index after reset", v, 0);
        bus_rd(8'h0C, v); chk(v == 0, "R10 status after reset", v, 0);
        bus_rd(8'h20, v); chk(v == 0, "R10 header after reset", v, 0);
        bus_rd(8'h24, v); chk(v == 0, "R10 data after reset", v, 0);

        // R1 mode readback, control reads zero
        bus_wr(8'h04, 32'hA5C3_0F1E);
        bus_rd(8'h04, v); chk(v == 32'hA5C3_0F1E, "R1 mode readback", v, 32'hA5C3_0F1E);
        bus_rd(8'h00, v); chk(v == 0, "R1 control reads zero", v, 0);

        // chain with terminator
        build(1'b1);
        run_target(0);
        run_target(1);
        run_target(term_pos - 1);
        run_target(term_pos);        // R7 zero-size header
        run_target(WORDS - 1);
        for (int i = 0; i < 30; i++) run_target(int'($urandom % WORDS));

        // R2 busy appears the cycle after go; R8 writes while busy are ignored
        bus_wr(8'h04, 32'(term_pos - 1) << 16);
        bus_wr(8'h00, 32'h40);
        bus_rd(8'h0C, v);
        chk(v[6] == 1'b1, "R2 busy after go", v, 32'h40);
        bus_wr(8'h04, 32'h0000_0000);
        bus_wr(8'h00, 32'h40);
        wait_idle();
        bus_rd(8'h20, v);
        chk(v == img[find_pkt(term_pos - 1)], "R8 target latched at start", v, img[find_pkt(term_pos - 1)]);
        repeat (4) @(posedge clk);
        bus_rd(8'h0C, v);
        chk(v == 0, "R8 busy go ignored", v, 0);
        bus_rd(8'h04, v);
        chk(v == 0, "R1 mode updated while busy", v, 0);

        // chain that runs off the array end
        build(1'b0);
        run_target(WORDS - 1);
        run_target(WORDS);           // R7 past array end
        run_target(16'hFFFF);
        for (int i = 0; i < 20; i++) run_target(int'($urandom % (WORDS + 8)));

        // R3 error clears on next start
        run_target(0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule